// File: doc/BRIEF.md
# Two-Digit Decimal Adder with Digit Validity Flag

This block adds two decimal numbers of two digits each, both held as packed decimal digits of four bits, together with a carry-in. It returns a three-digit decimal sum. The logic is purely combinational. Two identical digit slices form a chain. Each slice first forms a plain binary sum with a four-bit ripple chain of full adders. When that sum exceeds nine, the slice folds it back into the range 0 to 9 and raises its carry. The carry of the low slice feeds the high slice, and the carry of the high slice becomes the top sum digit.

The block also has four more outputs. It brings out the uncorrected binary sum and binary carry of the low digit, so that the raw adder can be observed. It raises a flag when any operand digit holds a code from 10 to 15. It drives seven-segment patterns for the four operand digits and the three sum digits. When the flag is high, the sum outputs are still formed by the same rule, but they carry no decimal meaning.

Top module: `dual_bcd_adder`

## Requirements
- R1: `{lo_bin_carry, lo_bin_sum}`, read as a 5-bit unsigned number, equals `a_lo + b_lo + cin` for every input code from 0 to 15, valid or not.
- R2: Let T0 = `a_lo + b_lo + cin`. If T0 > 9, `s0` = T0 − 10 and the carry into the high digit is 1. Otherwise `s0` = T0 and that carry is 0.
- R3: Let T1 = `a_hi + b_hi` + (the carry from R2). If T1 > 9, `s1` = T1 − 10 and the high carry is 1. Otherwise `s1` = T1 and the high carry is 0.
- R4: `s2` equals the high carry from R3, so its value is 0 or 1 and its bits 3 to 1 are always 0.
- R5: When all operand digits are 0 to 9, 100·`s2` + 10·`s1` + `s0` equals (10·`a_hi` + `a_lo`) + (10·`b_hi` + `b_lo`) + `cin`, and every sum digit is at most 9.
- R6: `digit_err` is 1 exactly when at least one of `a_hi`, `a_lo`, `b_hi`, `b_lo` is greater than 9.
- R7: Each operand segment output shows its digit. Bit 0 drives segment a, bit 1 segment b, and so on up to bit 6 for segment g, and a 1 lights the segment. The patterns for 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Codes 10 to 15 give 0x00 (blank).
- R8: `seg_s2`, `seg_s1` and `seg_s0` show `s2`, `s1` and `s0` with the same encoding as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_hi | input | 4 | Tens digit of operand A |
| a_lo | input | 4 | Units digit of operand A |
| b_hi | input | 4 | Tens digit of operand B |
| b_lo | input | 4 | Units digit of operand B |
| cin | input | 1 | Carry into the units digit |
| s2 | output | 4 | Hundreds digit of the sum (0 or 1) |
| s1 | output | 4 | Tens digit of the sum |
| s0 | output | 4 | Units digit of the sum |
| lo_bin_sum | output | 4 | Uncorrected binary sum of the units digit |
| lo_bin_carry | output | 1 | Binary carry out of the units ripple adder |
| digit_err | output | 1 | High when any operand digit exceeds 9 |
| seg_a_hi | output | 7 | Segment pattern for a_hi |
| seg_a_lo | output | 7 | Segment pattern for a_lo |
| seg_b_hi | output | 7 | Segment pattern for b_hi |
| seg_b_lo | output | 7 | Segment pattern for b_lo |
| seg_s2 | output | 7 | Segment pattern for s2 |
| seg_s1 | output | 7 | Segment pattern for s1 |
| seg_s0 | output | 7 | Segment pattern for s0 |

## Verification
The bench applies every valid operand pair with both carry-in values. This covers the sums of exactly 10 and exactly 19 per digit, where a correction test that checked only bit 4, or used "≥ 9", would leave the digit as 10 or skip the fold. It also covers 99 + 99 + 1, where a missing carry from the low digit to the high digit would drop the result by ten. A separate sweep over all 16×16 units codes checks that the raw binary outputs follow plain addition even above 9. The same sweep checks that the validity flag fires on every code from 10 to 15 in each operand position, so a comparator tied to the wrong bits or to a single operand would show up. The segment outputs are compared for every digit value, including blanking of the invalid codes.

// File: rtl/dbcd_pkg.sv
package dbcd_pkg;

    localparam int DIG_W   = 4;
    localparam int NUM_DIG = 2;
    localparam int SEG_W   = 7;
    localparam int MAX_DEC = 9;
    localparam int FOLD    = (1 << DIG_W) - (MAX_DEC + 1);

    typedef logic [DIG_W-1:0] digit_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef struct packed {
        logic   carry;
        digit_t sum;
    } bin_sum_t;

    typedef struct packed {
        logic   carry;
        digit_t digit;
    } dec_res_t;

    function automatic logic above_nine(input digit_t d);
        return int'(d) > MAX_DEC;
    endfunction

    function automatic seg_t seg_pattern(input digit_t d);
        seg_t p;
        case (d)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dbcd_fa.sv
module dbcd_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = x ^ y ^ ci;
    assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/dbcd_ripple.sv
module dbcd_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;
    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        dbcd_fa u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .co (chain[i+1])
        );
    end

    assign co = chain[W];

    always_comb begin
        p_ripple_sum_r1: assert (int'({co, s}) == int'(x) + int'(y) + int'(ci))
            else $error("ripple sum mismatch");
    end
endmodule

// File: rtl/dbcd_digit.sv
module dbcd_digit
    import dbcd_pkg::*;
(
    input  digit_t   a,
    input  digit_t   b,
    input  logic     ci,
    output bin_sum_t raw,
    output dec_res_t res
);
    logic fold;

    dbcd_ripple #(.W(DIG_W)) u_add (
        .x  (a),
        .y  (b),
        .ci (ci),
        .s  (raw.sum),
        .co (raw.carry)
    );

    assign fold      = raw.carry | above_nine(raw.sum);
    assign res.carry = fold;
    assign res.digit = fold ? digit_t'(raw.sum + digit_t'(FOLD)) : raw.sum;

    always_comb begin
        if (!above_nine(a) && !above_nine(b)) begin
            p_digit_range_r2: assert (int'(res.digit) <= MAX_DEC)
                else $error("digit out of decimal range");
            p_digit_value_r3: assert (int'(res.digit) + (MAX_DEC + 1) * int'(res.carry)
                                      == int'(a) + int'(b) + int'(ci))
                else $error("digit value mismatch");
        end
    end
endmodule

// File: rtl/dbcd_seg.sv
module dbcd_seg
    import dbcd_pkg::*;
(
    input  digit_t d,
    output seg_t   seg
);
    assign seg = seg_pattern(d);
endmodule

// File: rtl/dual_bcd_adder.sv
module dual_bcd_adder
    import dbcd_pkg::*;
(
    input  logic [3:0] a_hi,
    input  logic [3:0] a_lo,
    input  logic [3:0] b_hi,
    input  logic [3:0] b_lo,
    input  logic       cin,
    output logic [3:0] s2,
    output logic [3:0] s1,
    output logic [3:0] s0,
    output logic [3:0] lo_bin_sum,
    output logic       lo_bin_carry,
    output logic       digit_err,
    output logic [6:0] seg_a_hi,
    output logic [6:0] seg_a_lo,
    output logic [6:0] seg_b_hi,
    output logic [6:0] seg_b_lo,
    output logic [6:0] seg_s2,
    output logic [6:0] seg_s1,
    output logic [6:0] seg_s0
);
    localparam int NUM_SEG = 2 * NUM_DIG + NUM_DIG + 1;

    digit_t   op_a [NUM_DIG];
    digit_t   op_b [NUM_DIG];
    digit_t   sum_d[NUM_DIG];
    bin_sum_t raw  [NUM_DIG];
    dec_res_t res  [NUM_DIG];
    logic [NUM_DIG:0]   carry;
    logic [NUM_DIG-1:0] bad;
    digit_t seg_in [NUM_SEG];
    seg_t   seg_out[NUM_SEG];

    assign op_a[0]  = a_lo;
    assign op_a[1]  = a_hi;
    assign op_b[0]  = b_lo;
    assign op_b[1]  = b_hi;
    assign carry[0] = cin;

    for (genvar k = 0; k < NUM_DIG; k++) begin : g_dig
        dbcd_digit u_dig (
            .a   (op_a[k]),
            .b   (op_b[k]),
            .ci  (carry[k]),
            .raw (raw[k]),
            .res (res[k])
        );
        assign carry[k+1] = res[k].carry;
        assign sum_d[k]   = res[k].digit;
        assign bad[k]     = above_nine(op_a[k]) | above_nine(op_b[k]);
    end

    assign s0           = sum_d[0];
    assign s1           = sum_d[1];
    assign s2           = digit_t'(carry[NUM_DIG]);
    assign lo_bin_sum   = raw[0].sum;
    assign lo_bin_carry = raw[0].carry;
    assign digit_err    = |bad;

    assign seg_in[0] = a_hi;
    assign seg_in[1] = a_lo;
    assign seg_in[2] = b_hi;
    assign seg_in[3] = b_lo;
    assign seg_in[4] = s2;
    assign seg_in[5] = s1;
    assign seg_in[6] = s0;

    for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
        dbcd_seg u_seg (
            .d   (seg_in[j]),
            .seg (seg_out[j])
        );
    end

    assign seg_a_hi = seg_out[0];
    assign seg_a_lo = seg_out[1];
    assign seg_b_hi = seg_out[2];
    assign seg_b_lo = seg_out[3];
    assign seg_s2   = seg_out[4];
    assign seg_s1   = seg_out[5];
    assign seg_s0   = seg_out[6];

    always_comb begin
        p_top_digit_r4: assert (s2[3:1] == 3'b000)
            else $error("top digit wider than one bit");
        if (!digit_err) begin
            p_valid_sum_r5: assert (int'(s0) <= MAX_DEC && int'(s1) <= MAX_DEC)
                else $error("sum digit out of range with valid operands");
        end
    end
endmodule

// File: tb/sim_dual_bcd_adder.sv
module sim_dual_bcd_adder;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [3:0] a_hi, a_lo, b_hi, b_lo;
    logic       cin;
    logic [3:0] s2, s1, s0, lo_bin_sum;
    logic       lo_bin_carry, digit_err;
    logic [6:0] seg_a_hi, seg_a_lo, seg_b_hi, seg_b_lo, seg_s2, seg_s1, seg_s0;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    dual_bcd_adder u0 (
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .cin(cin),
        .s2(s2), .s1(s1), .s0(s0),
        .lo_bin_sum(lo_bin_sum), .lo_bin_carry(lo_bin_carry), .digit_err(digit_err),
        .seg_a_hi(seg_a_hi), .seg_a_lo(seg_a_lo), .seg_b_hi(seg_b_hi), .seg_b_lo(seg_b_lo),
        .seg_s2(seg_s2), .seg_s1(seg_s1), .seg_s0(seg_s0)
    );

    function automatic int seg_ref(int d);
        int lut[10] = '{'h3F, 'h06, 'h5B, 'h4F, 'h66, 'h6D, 'h7D, 'h07, 'h7F, 'h6F};
        if (d >= 0 && d <= 9) return lut[d];
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (a=%0d%0d b=%0d%0d cin=%0d)",
                     req, what, act, exp, a_hi, a_lo, b_hi, b_lo, cin);
        end
    endtask

    task automatic apply(int ah, int al, int bh, int bl, int c);
        @(posedge clk);
        a_hi = 4'(ah); a_lo = 4'(al); b_hi = 4'(bh); b_lo = 4'(bl); cin = 1'(c);
        @(negedge clk);
    endtask

    // Behavioural reference on integers, checked every clock.
    task automatic check_all(int ah, int al, int bh, int bl, int c, bit valid);
        int t0, t1, c1, c2, e0, e1;
        t0 = al + bl + c;
        chk("R1", "raw low sum", {27'd0, lo_bin_carry, lo_bin_sum}, t0);
        chk("R6", "digit_err", int'(digit_err),
            int'(ah > 9 || al > 9 || bh > 9 || bl > 9));
        chk("R7", "seg_a_hi", int'(seg_a_hi), seg_ref(ah));
        chk("R7", "seg_a_lo", int'(seg_a_lo), seg_ref(al));
        chk("R7", "seg_b_hi", int'(seg_b_hi), seg_ref(bh));
        chk("R7", "seg_b_lo", int'(seg_b_lo), seg_ref(bl));
        if (valid) begin
            c1 = (t0 > 9) ? 1 : 0;
            e0 = (t0 > 9) ? t0 - 10 : t0;
            t1 = ah + bh + c1;
            c2 = (t1 > 9) ? 1 : 0;
            e1 = (t1 > 9) ? t1 - 10 : t1;
            chk("R2", "s0", int'(s0), e0);
            chk("R3", "s1", int'(s1), e1);
            chk("R4", "s2", int'(s2), c2);
            chk("R5", "decimal total", 100 * int'(s2) + 10 * int'(s1) + int'(s0),
                (10 * ah + al) + (10 * bh + bl) + c);
            chk("R8", "seg_s0", int'(seg_s0), seg_ref(e0));
            chk("R8", "seg_s1", int'(seg_s1), seg_ref(e1));
            chk("R8", "seg_s2", int'(seg_s2), seg_ref(c2));
        end else begin
            chk("R4", "s2 upper bits", int'(s2[3:1]), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R5 actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        a_hi = 0; a_lo = 0; b_hi = 0; b_lo = 0; cin = 0;
        @(negedge clk);
        // Idle state with all-zero operands.
        chk("R5", "idle s0", int'(s0), 0);
        chk("R6", "idle err", int'(digit_err), 0);

        // Every valid pair, both carry-in values: R2 R3 R4 R5 R8.
        for (int a = 0; a < 100; a++) begin
            for (int b = 0; b < 100; b++) begin
                for (int c = 0; c < 2; c++) begin
                    apply(a / 10, a % 10, b / 10, b % 10, c);
                    check_all(a / 10, a % 10, b / 10, b % 10, c, 1'b1);
                end
            end
        end

        // Units codes 0..15 in both operands: R1 raw sum and R6 flag.
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(x % 10, x, y % 10, y, (x + y) % 2);
                check_all(x % 10, x, y % 10, y, (x + y) % 2, (x < 10 && y < 10));
            end
        end

        // Tens codes 0..15: R6 flag on high positions, R7 blanking.
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(x, 3, y, 4, 1);
                check_all(x, 3, y, 4, 1, (x < 10 && y < 10));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule